// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Selectable Stop Behaviour

This block produces one active-high pulse-width modulated output per channel (two channels by default). Each channel divides the input clock by a 6-bit prescaler, counts a 10-bit period and compares the count with a 10-bit duty value. A full-duty flag forces the output active for whole periods. A stop-mode bit chooses what happens when the channel's enable input drops. The output can stop at once, or it can run to the end of the current period first.

Software programs each channel through a simple register bus with write strobe, read strobe, address and data. The channel enable input stands in for the gated functional clock: the channel counts only while it is high. Values written to the prescaler, duty and period fields take effect only at a period boundary, so the output never shows a period made from mixed settings. While a channel is idle, the first cycle in which its enable is seen high loads the current settings.

Top module: `pwm_bank`

## Requirements
- R1: While a channel runs, its period is (P+1)*(V+1) clock cycles and its output is high for the first (P+1)*D cycles of each period. P is control bits [5:0], V is period bits [9:0] and D is duty bits [9:0]. Output sample k, counted from the first cycle after the clock edge that sees enable high on an idle channel, is high when floor(k/(P+1)) mod (V+1) < D.
- R2: D = 0 holds the output low for the whole period. D >= V+1 holds it high for the whole period.
- R3: When duty bit 10 is set, the output is high for the whole period, whatever D is.
- R4: Writes to the prescaler, duty or period fields of a running channel do not change the period in progress. They apply from the next period boundary.
- R5: When enable drops while control bit 6 is 0, the current period finishes unchanged. The output then goes low and stays low.
- R6: When enable drops while control bit 6 is 1, the output is low from the next clock edge. A later start begins again at count zero.
- R7: Channel n has its control register at n*0x10+0x0, its duty register at n*0x10+0x4 and its period register at n*0x10+0x8. Every field reads back its last written value, and bits outside the fields read as 0. Accesses to any other offset, or to a channel number at or above the channel count, read 0 and change no register.
- R8: Reset clears every register to 0 and drives every output low.
- R9: Channels are independent: programming or enabling one channel leaves the other channel's output and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is valid in the same cycle |
| addr | input | ADDR_W (8) | Byte address; bits [7:4] select the channel, bits [3:0] the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when not reading or when the address is unmapped |
| chan_en | input | NCH (2) | Per-channel run enable |
| pwm_out | output | NCH (2) | Per-channel active-high PWM output |

## Verification
The assertions check on every cycle that the period and prescale counters stay within their active limits, and that the active settings change only at a boundary. They also check that an abrupt stop idles the channel on the next edge, that a graceful stop keeps it running until the boundary, that writes to unmapped offsets leave the registers alone, and that reset leaves the outputs low. Only the bench's scenarios can show the actual waveform. These include the high time and period length over a sweep of prescale, period and duty values, the full-duty override, and the exact cycle at which mid-period writes take effect. They also include how far a graceful stop runs, the readback masks, and the independence of the two channels.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W     = 32;
    localparam int PS_W       = 6;
    localparam int CNT_W      = 10;
    localparam int ABRUPT_BIT = 6;
    localparam int FULL_BIT   = 10;
    localparam int OFF_W      = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic            abrupt;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    typedef struct packed {
        logic             full;
        logic [CNT_W-1:0] dc;
    } duty_t;

    // Programmed (shadow) settings of one channel
    typedef struct packed {
        ctrl_t            ctrl;
        duty_t            duty;
        logic [CNT_W-1:0] pv;
    } chan_cfg_t;

    // Settings in force for the current period
    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] pv;
        duty_t            duty;
    } live_cfg_t;

    typedef enum logic [1:0] {SEL_CTRL, SEL_DUTY, SEL_PER, SEL_NONE} reg_sel_e;

    typedef enum logic {CH_IDLE, CH_RUN} ch_state_e;

    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
        reg_sel_e s;
        case (off)
            4'h0:    s = SEL_CTRL;
            4'h4:    s = SEL_DUTY;
            4'h8:    s = SEL_PER;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic word_t ctrl_to_word(input ctrl_t c);
        word_t w = '0;
        w[PS_W-1:0]  = c.ps;
        w[ABRUPT_BIT] = c.abrupt;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input word_t w);
        ctrl_t c;
        c.ps     = w[PS_W-1:0];
        c.abrupt = w[ABRUPT_BIT];
        return c;
    endfunction

    function automatic word_t duty_to_word(input duty_t d);
        word_t w = '0;
        w[CNT_W-1:0] = d.dc;
        w[FULL_BIT]  = d.full;
        return w;
    endfunction

    function automatic duty_t word_to_duty(input word_t w);
        duty_t d;
        d.dc   = w[CNT_W-1:0];
        d.full = w[FULL_BIT];
        return d;
    endfunction

    function automatic word_t per_to_word(input logic [CNT_W-1:0] p);
        word_t w = '0;
        w[CNT_W-1:0] = p;
        return w;
    endfunction

    function automatic live_cfg_t snapshot(input chan_cfg_t c);
        live_cfg_t l;
        l.ps   = c.ctrl.ps;
        l.pv   = c.pv;
        l.duty = c.duty;
        return l;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  word_t                 wdata,
    output word_t                 rdata,
    output chan_cfg_t [NCH-1:0]   cfg_o
);

    localparam int IDX_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]    idx;
    reg_sel_e            sel;
    chan_cfg_t [NCH-1:0] cfg_q;

    assign idx   = addr[ADDR_W-1:OFF_W];
    assign sel   = decode_off(addr[OFF_W-1:0]);
    assign cfg_o = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(idx) == c) begin
                    case (sel)
                        SEL_CTRL: cfg_q[c].ctrl <= word_to_ctrl(wdata);
                        SEL_DUTY: cfg_q[c].duty <= word_to_duty(wdata);
                        SEL_PER:  cfg_q[c].pv   <= wdata[CNT_W-1:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(idx) == c) begin
                    case (sel)
                        SEL_CTRL: rdata = ctrl_to_word(cfg_q[c].ctrl);
                        SEL_DUTY: rdata = duty_to_word(cfg_q[c].duty);
                        SEL_PER:  rdata = per_to_word(cfg_q[c].pv);
                        default:  rdata = '0;
                    endcase
                end
            end
        end
    end

    // R7: a write to an unmapped offset leaves every register untouched
    p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> $stable(cfg_q))
        else $error("unmapped write changed a register");

endmodule

// File: rtl/pwm_tick.sv
module pwm_tick
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [PS_W-1:0] lim,
    output logic            tick
);

    logic [PS_W-1:0] pcnt;

    assign tick = !clr && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pcnt <= '0;
        else if (pcnt == lim)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // R1: the prescale count never passes its active limit while counting
    p_pcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (pcnt <= lim))
        else $error("prescale count beyond limit");

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  chan_cfg_t cfg,
    output logic      pwm_o
);

    ch_state_e        state;
    logic [CNT_W-1:0] cnt;
    live_cfg_t        act;
    logic             running;
    logic             tick;
    logic             wrap;
    logic             start;
    logic             kill;
    logic             pre_clr;

    assign running = (state == CH_RUN);
    assign start   = !running && en;
    assign kill    = running && !en && cfg.ctrl.abrupt;
    assign wrap    = tick && (cnt == act.pv);
    assign pre_clr = !running || kill;

    pwm_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .lim  (act.ps),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_IDLE;
            cnt   <= '0;
            act   <= '0;
        end else if (kill) begin
            state <= CH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            state <= CH_RUN;
            cnt   <= '0;
            act   <= snapshot(cfg);
        end else if (running && wrap) begin
            cnt <= '0;
            act <= snapshot(cfg);
            if (!en)
                state <= CH_IDLE;
        end else if (running && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwm_o = running && (act.duty.full || (cnt < act.duty.dc));

    // R1: period count stays within the active period value
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= act.pv))
        else $error("period count beyond limit");

    // R4: active settings hold between boundaries
    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (running && en && !wrap) |=> $stable(act))
        else $error("active settings changed mid-period");

    // R5: graceful stop keeps the channel running until the boundary
    p_graceful_r5: assert property (@(posedge clk) disable iff (rst)
        (running && !en && !cfg.ctrl.abrupt && !wrap) |=> running)
        else $error("graceful stop ended the period early");

    // R6: abrupt stop idles the channel and lowers the output on the next edge
    p_abrupt_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !en && cfg.ctrl.abrupt) |=> (!running && !pwm_o))
        else $error("abrupt stop did not take effect");

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    pwm_out
);

    chan_cfg_t [NCH-1:0] cfg;

    pwm_regs #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg_o (cfg)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            pwm_chan u_chan (
                .clk   (clk),
                .rst   (rst),
                .en    (chan_en[g]),
                .cfg   (cfg[g]),
                .pwm_o (pwm_out[g])
            );
        end
    endgenerate

    // R8: after a reset edge every output is low
    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (pwm_out == '0))
        else $error("output active after reset");

endmodule

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  chan_en = '0;
    logic [1:0]  pwm_out;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    logic samp [0:31];

    // 125 MHz: 8 ns period
    always #4 clk = ~clk;

    pwm_bank u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .chan_en (chan_en),
        .pwm_out (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_out(input int k, input int ps, input int pv,
                                     input int dc, input bit full);
        int c;
        c = (k / (ps + 1)) % (pv + 1);
        return full || (c < dc);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        rd_en = 1'b1; addr = a;
        #1;
        chk(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic start_ch(input int ch);
        @(posedge clk); #2;
        chan_en[ch] = 1'b1;
        @(posedge clk);
    endtask

    // One sweep point on channel 0, abrupt stop selected
    task automatic run_cfg(input int ps, input int pv, input int dc, input bit full);
        int    t;
        int    mism;
        string tag;
        wr(8'h00, 32'(ps) | 32'h40);
        wr(8'h04, 32'(dc) | (full ? 32'h400 : 32'h0));
        wr(8'h08, 32'(pv));
        start_ch(0);
        t = (ps + 1) * (pv + 1);
        mism = 0;
        for (int k = 0; k < 2 * t; k++) begin
            @(negedge clk);
            if (pwm_out[0] !== exp_out(k, ps, pv, dc, full)) mism++;
        end
        chan_en[0] = 1'b0;
        if (full) tag = "R3 full-duty pattern mismatches";
        else if (dc == 0 || dc > pv) tag = "R2 edge-duty pattern mismatches";
        else tag = "R1 waveform mismatches";
        chk(tag, mism, 0);
        @(negedge clk);
        chk("R6 output after abrupt stop", {31'b0, pwm_out[0]}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pvs [4] = '{0, 1, 2, 5};
        int mism;

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R8: reset state
        @(negedge clk);
        chk("R8 outputs after reset", {30'b0, pwm_out}, 0);
        rdchk(8'h00, 0, "R8 ch0 ctrl reset");
        rdchk(8'h04, 0, "R8 ch0 duty reset");
        rdchk(8'h08, 0, "R8 ch0 period reset");
        rdchk(8'h10, 0, "R8 ch1 ctrl reset");
        rdchk(8'h14, 0, "R8 ch1 duty reset");
        rdchk(8'h18, 0, "R8 ch1 period reset");

        // R7: readback masks and unmapped addresses
        wr(8'h00, 32'hFFFF_FFFF);
        rdchk(8'h00, 32'h7F, "R7 ctrl readback mask");
        wr(8'h04, 32'hFFFF_FFFF);
        rdchk(8'h04, 32'h7FF, "R7 duty readback mask");
        wr(8'h08, 32'hFFFF_FFFF);
        rdchk(8'h08, 32'h3FF, "R7 period readback mask");
        wr(8'h1C, 32'hFFFF_FFFF);
        rdchk(8'h1C, 0, "R7 unmapped offset reads zero");
        rdchk(8'h0C, 0, "R7 unmapped ch0 offset reads zero");
        wr(8'h24, 32'hFFFF_FFFF);
        rdchk(8'h24, 0, "R7 absent channel reads zero");
        rdchk(8'h10, 0, "R7 ch1 ctrl untouched by stray writes");
        rdchk(8'h14, 0, "R7 ch1 duty untouched by stray writes");
        rdchk(8'h18, 0, "R7 ch1 period untouched by stray writes");
        wr(8'h00, 32'h15);
        rdchk(8'h00, 32'h15, "R7 ctrl readback value");

        // R1 R2 R3 R6: sweep of prescale, period, duty and full flag
        for (int ps = 0; ps < 3; ps++)
            for (int i = 0; i < 4; i++)
                for (int dc = 0; dc <= pvs[i] + 2; dc++)
                    for (int f = 0; f < 2; f++)
                        run_cfg(ps, pvs[i], dc, f[0]);

        // R4: mid-period writes apply at the next boundary
        wr(8'h00, 32'h01);
        wr(8'h04, 32'h01);
        wr(8'h08, 32'h03);
        start_ch(0);
        fork
            begin
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    samp[k] = pwm_out[0];
                end
            end
            begin
                wr(8'h00, 32'h00);
                wr(8'h04, 32'h02);
                wr(8'h08, 32'h02);
            end
        join
        mism = 0;
        for (int k = 0; k < 16; k++) begin
            if (k < 8) begin
                if (samp[k] !== exp_out(k, 1, 3, 1, 1'b0)) mism++;
            end else begin
                if (samp[k] !== exp_out(k - 8, 0, 2, 2, 1'b0)) mism++;
            end
        end
        chk("R4 shadow load at boundary mismatches", mism, 0);
        chan_en[0] = 1'b0;
        repeat (8) @(posedge clk);

        // R5: graceful stop runs to the end of the period
        wr(8'h00, 32'h01);
        wr(8'h04, 32'h02);
        wr(8'h08, 32'h03);
        start_ch(0);
        fork
            begin
                for (int k = 0; k < 20; k++) begin
                    @(negedge clk);
                    samp[k] = pwm_out[0];
                end
            end
            begin
                repeat (9) @(posedge clk);
                #2 chan_en[0] = 1'b0;
            end
        join
        mism = 0;
        for (int k = 0; k < 20; k++)
            if (samp[k] !== ((k < 16) ? exp_out(k, 1, 3, 2, 1'b0) : 1'b0)) mism++;
        chk("R5 graceful stop mismatches", mism, 0);
        chk("R5 output high after enable dropped", {31'b0, samp[11]}, 1);

        // R6: abrupt stop cuts the period in the same spot
        wr(8'h00, 32'h41);
        wr(8'h04, 32'h400);
        start_ch(0);
        fork
            begin
                for (int k = 0; k < 20; k++) begin
                    @(negedge clk);
                    samp[k] = pwm_out[0];
                end
            end
            begin
                repeat (9) @(posedge clk);
                #2 chan_en[0] = 1'b0;
            end
        join
        mism = 0;
        for (int k = 0; k < 20; k++)
            if (samp[k] !== ((k < 10) ? 1'b1 : 1'b0)) mism++;
        chk("R6 abrupt stop mismatches", mism, 0);

        // R6: restart after abrupt stop begins at count zero
        wr(8'h04, 32'h02);
        start_ch(0);
        mism = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (pwm_out[0] !== exp_out(k, 1, 3, 2, 1'b0)) mism++;
        end
        chan_en[0] = 1'b0;
        chk("R6 restart from zero mismatches", mism, 0);
        repeat (3) @(posedge clk);

        // R9: channel 1 runs alone at offset 0x10
        wr(8'h10, 32'h42);
        wr(8'h14, 32'h01);
        wr(8'h18, 32'h02);
        start_ch(1);
        mism = 0;
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            if (pwm_out[1] !== exp_out(k, 2, 2, 1, 1'b0)) mism++;
            if (pwm_out[0] !== 1'b0) mism++;
        end
        chan_en[1] = 1'b0;
        chk("R9 channel 1 waveform and idle channel 0 mismatches", mism, 0);
        @(negedge clk);
        chk("R9 channel 1 stopped", {31'b0, pwm_out[1]}, 0);
        rdchk(8'h18, 32'h02, "R9 ch1 period readback");
        rdchk(8'h08, 32'h03, "R9 ch0 period unchanged by ch1 writes");
        rdchk(8'h04, 32'h02, "R9 ch0 duty unchanged by ch1 writes");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule